// File: doc/BRIEF.md
# PCM Sample Playback Voice

This block is one playback voice of a sample-based sound engine. Software programs a byte start address, a block length in 16-bit words, a sample period in clock ticks, a packed left/right gain and a mode word. When the enable input rises, the voice reads sample words from memory through a request/acknowledge port. At every sample boundary it consumes one 8-bit or 16-bit sample and produces scaled left and right outputs. At the end of each block it pulses a block-finished output. It then either restarts from the programmed registers or plays out and falls silent.

In stereo mode successive samples go to the left and then the right output. In mono mode each sample feeds both outputs, with its own gain on each side. If memory is slow, the voice holds its outputs and records an underrun instead of playing a stale word.

Top module: `pcm_voice`

## Requirements
- R1: After reset, and whenever the voice is not active, `left_o` and `right_o` are zero, `active_o` is low and no memory request is made.
- R2: A rising `en_i` loads the pointer and word count from the registers (select 0 = start byte address, 1 = length in words, bits 23:0). The first fetch goes to the start address. Later fetches go to ascending addresses in steps of 2, and `mem_req_o` and `mem_addr_o` hold steady until `mem_ack_i`.
- R3: Outputs update with `sample_stb_o` once every period ticks (select 2, bits 15:0). Periods below 2 count as 2. A new period applies from the next sample boundary.
- R4: With mode bit 0 set, every fetched word is one signed 16-bit sample.
- R5: With mode bit 0 clear, every word gives two signed 8-bit samples, high byte first. Each byte is placed in the upper half of a 16-bit value.
- R6: Each output is the sample times its gain, arithmetic-shifted right by 7 and saturated to 16 bits. The left gain is in bits 15:8 of the volume register (select 3) and the right gain in bits 7:0. A gain above 128 acts as 128. A new volume applies from the next sample.
- R7: With mode bit 2 clear, both outputs take the same sample. With it set, samples alternate left then right starting from left at enable, and the other output holds.
- R8: `block_done_o` pulses for one cycle, together with `sample_stb_o`, on the last sample of a block. With mode bit 1 clear, the next block starts from the register values current at that moment, including address, length and mode.
- R9: With mode bit 1 set, one period after the last sample the outputs go to zero and `active_o` falls. No further fetches are made.
- R10: A sample boundary that finds no fetched word holds both outputs, gives no strobe, and sets `underrun_o`. The flag stays set until the next rising `en_i`.
- R11: Mode bits 4:3 are ignored (the mode register is select 4).
- R12: A low `en_i` stops the voice on the next clock and zeroes both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Playback enable, starts on rising edge |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0 address, 1 length, 2 period, 3 volume, 4 mode) |
| wr_data_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | 32 | Fetch byte address |
| mem_ack_i | input | 1 | Fetch acknowledge, data valid |
| mem_data_i | input | 16 | Fetched word, big-endian |
| left_o | output | 16 | Left output sample, signed |
| right_o | output | 16 | Right output sample, signed |
| sample_stb_o | output | 1 | Outputs updated this cycle |
| block_done_o | output | 1 | Last sample of block played |
| active_o | output | 1 | Voice is playing |
| underrun_o | output | 1 | Sticky late-fetch flag |

## Verification
The hardest situation to reach is a register rewrite that has to land inside a running block. A new address must wait for the reload. A new period or gain must apply from the very next sample. The bench reaches this by watching the strobe and writing right after a chosen sample, so each pending write falls between two known boundaries. It then checks both the sample values and the measured strobe spacing. Underrun is forced by stretching the memory model's acknowledge latency past the period. Clamping to the minimum period is forced by programming a period of 1.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR = 3'd0,
    SEL_LEN  = 3'd1,
    SEL_PER  = 3'd2,
    SEL_VOL  = 3'd3,
    SEL_MODE = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic stereo;
    logic oneshot;
    logic wide;
  } mode_t;
endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
  import pcm_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 24,
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [31:0]   data_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic [PW-1:0] per_o,
  output logic [15:0]   vol_o,
  output mode_t         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      len_o  <= '0;
      per_o  <= PW'(2);
      vol_o  <= '0;
      mode_o <= '0;
    end else if (wr_i) begin
      unique case (reg_sel_e'(sel_i))
        SEL_ADDR: addr_o <= data_i[AW-1:0];
        SEL_LEN:  len_o  <= data_i[LW-1:0];
        SEL_PER:  per_o  <= data_i[PW-1:0];
        SEL_VOL:  vol_o  <= data_i[15:0];
        SEL_MODE: mode_o <= mode_t'(data_i[2:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcm_timer.sv
module pcm_timer #(
  parameter int PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [PW-1:0] period_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_eff;

  assign per_eff = (period_i < PW'(2)) ? PW'(2) : period_i;
  assign tick_o  = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i || tick_o)  cnt_q <= per_eff - PW'(1);
    else if (run_i)             cnt_q <= cnt_q - PW'(1);
  end
endmodule

// File: rtl/pcm_gain.sv
module pcm_gain #(
  parameter int SW = 16,
  parameter int GW = 8,
  parameter int UNITY = 128
) (
  input  logic signed [SW-1:0] sample_i,
  input  logic        [GW-1:0] gain_i,
  output logic signed [SW-1:0] out_o
);
  localparam int PRW = SW + GW + 1;
  localparam int SH  = $clog2(UNITY);
  localparam logic signed [PRW-1:0] MAXV = PRW'((2 ** (SW - 1)) - 1);
  localparam logic signed [PRW-1:0] MINV = -PRW'(2 ** (SW - 1));

  logic [GW-1:0]          g_eff;
  logic signed [PRW-1:0]  prod;
  logic signed [PRW-1:0]  shifted;

  assign g_eff   = (gain_i > GW'(UNITY)) ? GW'(UNITY) : gain_i;
  assign prod    = sample_i * $signed({1'b0, g_eff});
  assign shifted = prod >>> SH;
  assign out_o   = (shifted > MAXV) ? MAXV[SW-1:0] :
                   (shifted < MINV) ? MINV[SW-1:0] : shifted[SW-1:0];
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
  import pcm_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 24,
  parameter int PW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [31:0]   wr_data_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          sample_stb_o,
  output logic          block_done_o,
  output logic          active_o,
  output logic          underrun_o
);
  localparam int BW = DW / 2;
  localparam int STEP = DW / 8;

  logic [AW-1:0] reg_addr;
  logic [LW-1:0] reg_len;
  logic [PW-1:0] reg_per;
  logic [15:0]   reg_vol;
  mode_t         reg_mode;

  pcm_regs #(.AW(AW), .LW(LW), .PW(PW)) u_regs (
    .clk_i, .rst_ni, .wr_i,
    .sel_i(wr_sel_i), .data_i(wr_data_i),
    .addr_o(reg_addr), .len_o(reg_len), .per_o(reg_per),
    .vol_o(reg_vol), .mode_o(reg_mode)
  );

  logic en_q, start, tick;
  logic active_q, tail_q, have_q, sub_q, lr_q, last_q, stb_q, done_q, undr_q;
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] cnt_q;
  mode_t         mode_q;
  logic [DW-1:0] word_q;
  logic [DW-1:0] left_q, right_q;

  assign start = en_i && !en_q;

  pcm_timer #(.PW(PW)) u_timer (
    .clk_i, .rst_ni,
    .load_i(start), .run_i(active_q), .period_i(reg_per), .tick_o(tick)
  );

  logic signed [DW-1:0] smp;
  logic signed [DW-1:0] scaled [2];
  assign smp = mode_q.wide ? word_q
                           : {(sub_q ? word_q[BW-1:0] : word_q[DW-1:BW]), BW'(0)};

  for (genvar s = 0; s < 2; s++) begin : g_side
    pcm_gain #(.SW(DW), .GW(8), .UNITY(128)) u_gain (
      .sample_i(smp),
      .gain_i(s == 0 ? reg_vol[15:8] : reg_vol[7:0]),
      .out_o(scaled[s])
    );
  end

  assign mem_req_o    = active_q && !have_q && !tail_q;
  assign mem_addr_o   = ptr_q;
  assign left_o       = left_q;
  assign right_o      = right_q;
  assign sample_stb_o = stb_q;
  assign block_done_o = done_q;
  assign active_o     = active_q;
  assign underrun_o   = undr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; active_q <= 1'b0; tail_q <= 1'b0; have_q <= 1'b0;
      sub_q <= 1'b0; lr_q <= 1'b0; last_q <= 1'b0; stb_q <= 1'b0;
      done_q <= 1'b0; undr_q <= 1'b0; ptr_q <= '0; cnt_q <= '0;
      mode_q <= '0; word_q <= '0; left_q <= '0; right_q <= '0;
    end else begin
      en_q   <= en_i;
      stb_q  <= 1'b0;
      done_q <= 1'b0;
      if (!en_i) begin
        active_q <= 1'b0; tail_q <= 1'b0; have_q <= 1'b0;
        left_q <= '0; right_q <= '0;
      end else if (start) begin
        active_q <= 1'b1; tail_q <= 1'b0; have_q <= 1'b0;
        sub_q <= 1'b0; lr_q <= 1'b0; undr_q <= 1'b0;
        ptr_q <= reg_addr; cnt_q <= reg_len; mode_q <= reg_mode;
        left_q <= '0; right_q <= '0;
      end else if (active_q) begin
        if (mem_req_o && mem_ack_i) begin
          word_q <= mem_data_i;
          have_q <= 1'b1;
          ptr_q  <= ptr_q + AW'(STEP);
          cnt_q  <= cnt_q - LW'(1);
          last_q <= (cnt_q <= LW'(1));
        end
        if (tick) begin
          if (tail_q) begin
            active_q <= 1'b0; tail_q <= 1'b0;
            left_q <= '0; right_q <= '0;
          end else if (have_q) begin
            stb_q <= 1'b1;
            lr_q  <= !lr_q;
            if (!mode_q.stereo || !lr_q) left_q  <= scaled[0];
            if (!mode_q.stereo ||  lr_q) right_q <= scaled[1];
            if (mode_q.wide || sub_q) begin
              have_q <= 1'b0;
              sub_q  <= 1'b0;
              if (last_q) begin
                done_q <= 1'b1;
                if (mode_q.oneshot) tail_q <= 1'b1;
                else begin
                  ptr_q <= reg_addr; cnt_q <= reg_len; mode_q <= reg_mode;
                end
              end
            end else begin
              sub_q <= 1'b1;
            end
          end else begin
            undr_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_voice_chk.sv
module pcm_voice_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          en_i,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          sample_stb_o,
  input logic          block_done_o,
  input logic          active_o,
  input logic          underrun_o
);
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (left_o == '0 && right_o == '0)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && en_i) |=> (!en_i || (mem_req_o && $stable(mem_addr_o)))); // R2
  AST_STB_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |-> active_o); // R3
  AST_DONE_WITH_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> sample_stb_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |=> !block_done_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> (sample_stb_o || !active_o)); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !start_i) |=> underrun_o); // R10
endmodule

bind pcm_voice pcm_voice_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .en_i(en_i),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .left_o(left_o), .right_o(right_o), .sample_stb_o(sample_stb_o),
  .block_done_o(block_done_o), .active_o(active_o), .underrun_o(underrun_o)
);

// File: tb/pcm_voice_tb.sv
module pcm_voice_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b0, wr = 1'b0;
  logic [2:0] sel = '0;
  logic [31:0] wdata = '0;
  logic mem_req, mem_ack = 1'b0, stb, done, active, undr;
  logic [31:0] mem_addr;
  logic [15:0] mem_data = '0, left, right;

  always #2 clk = ~clk;

  pcm_voice u_dut (
    .clk_i(clk), .rst_ni, .en_i(en), .wr_i(wr), .wr_sel_i(sel), .wr_data_i(wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
    .left_o(left), .right_o(right), .sample_stb_o(stb), .block_done_o(done),
    .active_o(active), .underrun_o(undr)
  );

  int errors = 0, checks = 0, done_cnt = 0, ack_lat = 0, wait_n = 0;
  int unsigned cyc = 0;
  bit arm_first = 0;
  logic [31:0] first_addr = '0;
  logic [15:0] mem [64];
  logic [31:0] exp_q [$];
  string cur_req = "R4";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] scale(input int s, input int g);
    int gg, p;
    gg = (g > 128) ? 128 : g;
    p = (s * gg) >>> 7;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  always @(posedge clk) cyc++;

  // memory model
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_n >= ack_lat) begin
        mem_ack = 1'b1;
        mem_data = mem[mem_addr[6:1]];
        wait_n = 0;
        if (arm_first) begin first_addr = mem_addr; arm_first = 0; end
      end else wait_n++;
    end else wait_n = 0;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (done) done_cnt++;
      if (stb) begin
        if (exp_q.size() == 0) chk(0, {cur_req, " unexpected sample"}, {left, right}, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({left, right} == e, {cur_req, " sample"}, {left, right}, e);
        end
      end
    end
  end

  task automatic wreg(input int s, input int d);
    sel = 3'(s); wdata = 32'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!stb);
  endtask

  function automatic int peff(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic run_case(input string tag, input int base0, input int base1, input int len,
                          input int nblk, input int per0, input int per1, input int vol0,
                          input int vol1, input int ctl, input int gap_n);
    int l = 0, r = 0, k = 0;
    bit lr = 0;
    int unsigned t0, t1, t2;
    cur_req = tag;
    wreg(0, base0); wreg(1, len); wreg(2, per0); wreg(3, vol0); wreg(4, ctl);
    for (int b = 0; b < nblk; b++) begin
      int base = (b == 0) ? base0 : base1;
      for (int w = 0; w < len; w++) begin
        logic [15:0] wd = mem[((base >> 1) + w) & 63];
        for (int h = 0; h < (ctl[0] ? 1 : 2); h++) begin
          logic [15:0] t;
          int s, v;
          t = ctl[0] ? wd : {(h == 0 ? wd[15:8] : wd[7:0]), 8'h00};
          s = $signed(t);
          v = (k == 0) ? vol0 : vol1;
          if (!ctl[2]) begin l = scale(s, (v >> 8) & 255); r = scale(s, v & 255); end
          else if (!lr) l = scale(s, (v >> 8) & 255);
          else r = scale(s, v & 255);
          lr = !lr;
          exp_q.push_back({l[15:0], r[15:0]});
          k++;
        end
      end
    end
    done_cnt = 0;
    arm_first = 1;
    en = 1'b1;
    @(negedge clk);
    if (base1 != base0) begin @(negedge clk); wreg(0, base1); end
    if (gap_n > 0 || vol1 != vol0 || per1 != per0) begin
      wait_stb(); t0 = cyc;
      if (vol1 != vol0) wreg(3, vol1);
      if (per1 != per0) wreg(2, per1);
      if (gap_n > 0) begin
        wait_stb(); t1 = cyc;
        chk(int'(t1 - t0) == peff(per0), "R3 first gap", t1 - t0, peff(per0));
        if (gap_n > 1) begin
          wait_stb(); t2 = cyc;
          chk(int'(t2 - t1) == peff(per1), "R3 gap after change", t2 - t1, peff(per1));
        end
      end
    end
    while (exp_q.size() != 0) @(negedge clk);
    chk(first_addr == 32'(base0), "R2 first fetch address", first_addr, base0);
    if (ctl[1]) begin
      for (int i = 0; i < 3 * peff(per1) + 8 && active; i++) @(negedge clk);
      chk(!active, "R9 active falls", active, 0);
      chk(left == 0 && right == 0, "R9 outputs zero", {left, right}, 0);
      chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);
      repeat (8) @(negedge clk);
      chk(!mem_req && exp_q.size() == 0, "R9 no fetch after end", mem_req, 0);
    end else begin
      en = 1'b0;
      @(negedge clk);
      chk(!active && left == 0 && right == 0, "R12 stop on enable low", {active, left, right}, 0);
      chk(done_cnt == nblk, "R8 done count", done_cnt, nblk);
    end
    en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357 + 16'h0A5C);
    mem[0] = 16'h7FFF; mem[1] = 16'h8000; mem[2] = 16'h0001;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!active && !mem_req && left == 0 && right == 0 && !undr, "R1 reset state",
        {active, mem_req, undr, left[12:0], right[15:0]}, 0);
    // 16-bit mono one-shot with full-scale words
    run_case("R4/R7", 0, 0, 3, 1, 4, 4, 32'h8040, 32'h8040, 3, 1);
    // 8-bit mono continuous, address rewritten during first block
    run_case("R5/R8", 8, 20, 2, 3, 5, 5, 32'h6420, 32'h6420, 0, 0);
    // stereo 16-bit continuous, left gain above ceiling
    run_case("R6/R7", 40, 40, 3, 2, 4, 4, 32'hFF80, 32'hFF80, 32'h5, 0);
    // period and volume change during playback
    run_case("R3/R6", 30, 30, 4, 1, 6, 9, 32'h8080, 32'h2010, 1, 2);
    // reserved mode bits set
    run_case("R11", 50, 50, 2, 1, 4, 4, 32'h4070, 32'h4070, 32'h1B, 0);
    chk(!undr, "R10 no underrun with fast memory", undr, 0);
    // late acknowledge
    ack_lat = 12;
    run_case("R10", 60, 60, 2, 1, 4, 4, 32'h8080, 32'h8080, 3, 0);
    chk(undr, "R10 underrun flagged", undr, 1);
    ack_lat = 0;
    run_case("R10", 10, 10, 1, 1, 4, 4, 32'h8080, 32'h8080, 3, 0);
    chk(!undr, "R10 flag cleared on restart", undr, 0);
    // period below minimum
    run_case("R3", 12, 12, 1, 1, 1, 1, 32'h8080, 32'h8080, 2, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule